// File: doc/BRIEF.md
# Split-Memory-Stage Pipeline Interlock

This block is the hazard logic and stage registers for an in-order pipeline whose memory access takes two stages, M0 and then M1, with a register between them and writeback after M1. The memory behind those two stages can serve only one access at a time, so a memory operation holds the memory for both of its stages. Operations that do not touch memory pass through M0 and M1 like any other stage.

Each stage register carries a valid bit, a memory-operation flag and an instruction tag. When the instruction in execute is a memory operation and the instruction in M0 is one too, the interlock raises a front-end stall and writes an empty slot into M0. The older operation moves on into M1 and the younger one waits in execute for one cycle. The fetch input takes a new instruction only while the front end is not stalled. Instructions leave writeback through the retire outputs.

Top module: `mem2_interlock`

## Requirements
- R1: During reset and on the first cycle after it, `retire_valid`, `m0_mem_busy`, `m1_mem_busy` and `stall_front` are all 0 and `in_ready` is 1.
- R2: `stall_front` is 1 only in a cycle where M0 holds a valid memory operation (`m0_mem_busy` = 1) and execute holds another.
- R3: A stall lasts one cycle. No two consecutive cycles have `stall_front` high.
- R4: While `stall_front` is 1, `in_ready` is 0 and no input instruction is taken. An instruction that is offered is taken in a later cycle, and none is lost or duplicated.
- R5: In the cycle after a stall, M0 holds an empty slot (`m0_mem_busy` = 0) and the older memory operation is in M1 (`m1_mem_busy` = 1). `bubble_m0` is high in every stall cycle.
- R6: `m0_mem_busy` and `m1_mem_busy` are never both 1.
- R7: Instructions with `in_is_mem` = 0 never cause a stall. This includes a stream of such instructions and one placed directly after a memory operation.
- R8: Instructions retire in the order they were taken, each once, with their tag and memory flag unchanged. With no stall and the default two front stages, an instruction retires six clock edges after the cycle in which it is offered with `in_ready` high.
- R9: Two memory operations never retire on consecutive cycles.
- R10: Three memory operations in a row produce exactly two stall cycles. The pattern memory, non-memory, memory produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered to fetch |
| in_is_mem | input | 1 | The offered instruction uses the memory |
| in_tag | input | IL_TAG_W | Tag of the offered instruction |
| in_ready | output | 1 | Fetch takes the offered instruction at this edge |
| stall_front | output | 1 | Fetch, decode and execute hold this cycle |
| bubble_m0 | output | 1 | An empty slot is written into M0 at this edge |
| m0_mem_busy | output | 1 | M0 holds a valid memory operation |
| m1_mem_busy | output | 1 | M1 holds a valid memory operation |
| retire_valid | output | 1 | Writeback holds a valid instruction |
| retire_is_mem | output | 1 | Memory flag of the retiring instruction |
| retire_tag | output | IL_TAG_W | Tag of the retiring instruction |

## Verification
If the hazard test misses a case, both memory-busy outputs go high within one cycle of two memory operations becoming adjacent, and memory operations retire on consecutive cycles two cycles after that. If the hold or bubble logic is wrong, a tag retires twice or never retires, and the scoreboard reports it when that slot reaches writeback, about five cycles later. An unneeded stall changes the stall count of a pattern or the fixed retire latency, and this shows up as soon as the affected instruction drains.

// File: rtl/il_pkg.sv
// Package: shared types for the split-memory-stage interlock.
// Assumes: tags are small and only used to check order.
package il_pkg;
    parameter int IL_TAG_W = 8;

    typedef struct packed {
        logic                valid;
        logic                is_mem;
        logic [IL_TAG_W-1:0] tag;
    } il_slot_t;

    localparam il_slot_t IL_EMPTY = '{valid: 1'b0, is_mem: 1'b0, tag: '0};
endpackage

// File: rtl/il_stage_reg.sv
// Module: one pipeline stage register holding a slot.
// Priority: reset, then bubble insert, then hold, then load.
// Assumes: hold and bubble come from the hazard unit in the same cycle.
module il_stage_reg
    import il_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hold,
    input  logic     bubble,
    input  il_slot_t d,
    output il_slot_t q
);
    // Update the stored slot on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= IL_EMPTY;
        else if (bubble)
            q <= IL_EMPTY;
        else if (!hold)
            q <= d;
    end
endmodule

// File: rtl/il_hazard.sv
// Module: structural-hazard detector for the shared two-stage memory.
// Raises a stall when execute and M0 both hold valid memory operations.
// Assumes: the memory serves one access over the whole of M0 and M1.
module il_hazard
    import il_pkg::*;
(
    input  il_slot_t ex_slot,
    input  il_slot_t m0_slot,
    output logic     stall,
    output logic     bubble
);
    logic ex_mem, m0_mem;

    // Decide the stall and the M0 bubble from the two stage slots.
    always_comb begin
        ex_mem = ex_slot.valid & ex_slot.is_mem;
        m0_mem = m0_slot.valid & m0_slot.is_mem;
        stall  = ex_mem & m0_mem;
        bubble = stall;
    end
endmodule

// File: rtl/mem2_interlock.sv
// Module: front stages, execute, M0, M1 and writeback registers with the
// interlock that keeps memory operations one cycle apart.
// Assumes: FRONT_STAGES >= 1 (fetch first, then the decode stages).
module mem2_interlock
    import il_pkg::*;
#(
    parameter int FRONT_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_is_mem,
    input  logic [IL_TAG_W-1:0] in_tag,
    output logic                in_ready,
    output logic                stall_front,
    output logic                bubble_m0,
    output logic                m0_mem_busy,
    output logic                m1_mem_busy,
    output logic                retire_valid,
    output logic                retire_is_mem,
    output logic [IL_TAG_W-1:0] retire_tag
);
    localparam int LAST_FRONT = FRONT_STAGES - 1;

    il_slot_t in_slot;
    il_slot_t front_q [FRONT_STAGES];
    il_slot_t ex_q, m0_q, m1_q, wb_q;
    logic     stall, bubble;

    // Pack the fetch input into a slot.
    always_comb begin
        in_slot.valid  = in_valid;
        in_slot.is_mem = in_is_mem;
        in_slot.tag    = in_tag;
    end

    il_hazard u_hazard (
        .ex_slot (ex_q),
        .m0_slot (m0_q),
        .stall   (stall),
        .bubble  (bubble)
    );

    generate
        for (genvar i = 0; i < FRONT_STAGES; i++) begin : g_front
            if (i == 0) begin : g_fetch
                il_stage_reg u_reg (
                    .clk (clk), .rst_n (rst_n), .hold (stall), .bubble (1'b0),
                    .d (in_slot), .q (front_q[i])
                );
            end else begin : g_dec
                il_stage_reg u_reg (
                    .clk (clk), .rst_n (rst_n), .hold (stall), .bubble (1'b0),
                    .d (front_q[i-1]), .q (front_q[i])
                );
            end
        end
    endgenerate

    il_stage_reg u_ex (
        .clk (clk), .rst_n (rst_n), .hold (stall), .bubble (1'b0),
        .d (front_q[LAST_FRONT]), .q (ex_q)
    );

    il_stage_reg u_m0 (
        .clk (clk), .rst_n (rst_n), .hold (1'b0), .bubble (bubble),
        .d (ex_q), .q (m0_q)
    );

    il_stage_reg u_m1 (
        .clk (clk), .rst_n (rst_n), .hold (1'b0), .bubble (1'b0),
        .d (m0_q), .q (m1_q)
    );

    il_stage_reg u_wb (
        .clk (clk), .rst_n (rst_n), .hold (1'b0), .bubble (1'b0),
        .d (m1_q), .q (wb_q)
    );

    // Drive the status and retire outputs from the stage registers.
    always_comb begin
        in_ready      = ~stall;
        stall_front   = stall;
        bubble_m0     = bubble;
        m0_mem_busy   = m0_q.valid & m0_q.is_mem;
        m1_mem_busy   = m1_q.valid & m1_q.is_mem;
        retire_valid  = wb_q.valid;
        retire_is_mem = wb_q.is_mem;
        retire_tag    = wb_q.tag;
    end
endmodule

// File: rtl/mem2_interlock_chk.sv
// Module: assertion checker for mem2_interlock, attached by bind.
// Assumes: it sees only the ports of the top module.
module mem2_interlock_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic stall_front,
    input logic bubble_m0,
    input logic m0_mem_busy,
    input logic m1_mem_busy,
    input logic retire_valid,
    input logic retire_is_mem
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!retire_valid && !m0_mem_busy && !m1_mem_busy && in_ready));

    assert_stall_needs_m0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front |-> m0_mem_busy);

    assert_stall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front |=> !stall_front);

    assert_bubble_after_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front |=> (!m0_mem_busy && m1_mem_busy));

    assert_one_mem_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(m0_mem_busy && m1_mem_busy));

    assert_mem_retire_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && retire_is_mem) |=> !(retire_valid && retire_is_mem));

    assert_bubble_marks_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front |-> bubble_m0);
endmodule

bind mem2_interlock mem2_interlock_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .stall_front   (stall_front),
    .bubble_m0     (bubble_m0),
    .m0_mem_busy   (m0_mem_busy),
    .m1_mem_busy   (m1_mem_busy),
    .retire_valid  (retire_valid),
    .retire_is_mem (retire_is_mem)
);

// File: tb/sim_mem2_interlock.sv
// Bench: scoreboard for mem2_interlock. The driver queues each instruction
// as it is taken, and the monitor pops the queue as instructions retire.
module sim_mem2_interlock;
    import il_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_is_mem = 1'b0;
    logic [IL_TAG_W-1:0] in_tag = '0;
    logic                in_ready, stall_front, bubble_m0;
    logic                m0_mem_busy, m1_mem_busy;
    logic                retire_valid, retire_is_mem;
    logic [IL_TAG_W-1:0] retire_tag;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int stall_cnt = 0;
    int last_retire_cyc = -10;
    int last_mem_retire_cyc = -10;
    int issue_cyc = 0;
    logic [IL_TAG_W-1:0] next_tag = '0;
    logic [IL_TAG_W:0] exp_q [$];
    logic prev_stall = 1'b0;
    logic done = 1'b0;

    mem2_interlock u0 (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Offer one instruction and wait until fetch takes it.
    task automatic issue(input bit mem);
        @(negedge clk);
        in_valid  = 1'b1;
        in_is_mem = mem;
        in_tag    = next_tag;
        while (!in_ready) @(negedge clk);
        exp_q.push_back({mem, next_tag});
        issue_cyc = cyc;
        next_tag  = next_tag + 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare retires with the queue and watch the interlock outputs.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_front) stall_cnt++;
            if (m0_mem_busy && m1_mem_busy)
                check(1'b0, "R6", 1, 0);
            if (stall_front && prev_stall)
                check(1'b0, "R3", 2, 1);
            if (stall_front && in_ready)
                check(1'b0, "R4", 1, 0);
            if (prev_stall && (m0_mem_busy || !m1_mem_busy))
                check(1'b0, "R5", int'(m0_mem_busy), 0);
            if (stall_front && !bubble_m0)
                check(1'b0, "R5", 0, 1);
            prev_stall = stall_front;
            if (retire_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", int'(retire_tag), -1);
                end else begin
                    logic [IL_TAG_W:0] e;
                    e = exp_q.pop_front();
                    check({retire_is_mem, retire_tag} == e, "R8",
                          int'({retire_is_mem, retire_tag}), int'(e));
                end
                if (retire_is_mem) begin
                    if (cyc - last_mem_retire_cyc < 2)
                        check(1'b0, "R9", cyc - last_mem_retire_cyc, 2);
                    last_mem_retire_cyc = cyc;
                end
                last_retire_cyc = cyc;
            end
        end
    end

    // Run a pattern and check how many stall cycles it produced.
    task automatic pattern(input bit [7:0] mems, input int n, input int exp_stalls, input string req);
        idle(1);
        stall_cnt = 0;
        for (int i = 0; i < n; i++) issue(mems[i]);
        idle(12);
        check(stall_cnt == exp_stalls, req, stall_cnt, exp_stalls);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!retire_valid && !m0_mem_busy && !m1_mem_busy && !stall_front && in_ready,
              "R1", int'({retire_valid, m0_mem_busy, m1_mem_busy, stall_front, in_ready}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!retire_valid && !stall_front && in_ready, "R1",
              int'({retire_valid, stall_front, in_ready}), 1);

        // R8 latency of a single non-memory instruction
        issue(1'b0);
        idle(10);
        check(last_retire_cyc - issue_cyc == 6, "R8", last_retire_cyc - issue_cyc, 6);

        pattern(8'b0000_0011, 2, 1, "R2");          // two memory ops back to back
        pattern(8'b0000_0111, 3, 2, "R10");         // three in a row
        pattern(8'b0000_0101, 3, 0, "R10");         // mem, non-mem, mem
        pattern(8'b0000_0000, 8, 0, "R7");          // non-memory stream
        pattern(8'b0000_1101, 4, 1, "R7");          // mem, non-mem after it, then two mem
        pattern(8'b1111_1111, 8, 7, "R4");          // long memory run, all held inputs kept
        pattern(8'b0110_1011, 8, 2, "R9");          // mixed

        // Pseudo-random mixed streams: no stall count predicted, order checked.
        for (int r = 0; r < 40; r++) begin
            issue(((r * 7 + 3) % 5) < 2);
            if (r % 9 == 0) idle(1);
        end
        idle(15);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int w;
        w = 0;
        while (!done && w < 20000) begin
            @(posedge clk);
            w++;
        end
        if (!done) check(1'b0, "watchdog", w, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule